// File: doc/BRIEF.md
# Complementary PWM Pair Shaper with Deadband

This block turns three per-pair compare states into six switch-drive outputs, grouped as three complementary pairs. For every output a two-bit action code picks one of four behaviours: hold the pin low, hold it high, follow the pair's compare state, or follow its inversion. Each pair has its own enable, and a disabled pair keeps both of its pins low.

Between the requested level and the pin sits a deadband stage. It holds back every rising edge by a programmable number of clock cycles, so the two transistors of a half bridge are never switched on together. Falling edges pass through without that extra delay. The delay is a four-bit period multiplied by a power-of-two prescale, from 1 to 32. A new delay setting is picked up only while no output is waiting out a delay, so a dead time already in progress is never cut short or stretched. The counter that produces the compare states sits outside this block.

Top module: `pwm_pair_shaper`

## Requirements
- R1: While `rstN` is low, all six outputs are low.
- R2: Action code 2'b00 drives the output low whatever the compare state is.
- R3: Action code 2'b11 drives the output high (after any deadband) whatever the compare state is.
- R4: Action code 2'b10 requests high while the pair's compare input is 1. Action code 2'b01 requests the inverse.
- R5: Output n (n = 1..6, `pwmOut[n-1]`) takes its code from `actionWord[2n-1:2n-2]` and belongs to pair (n+1)/2, which uses `cmpMatch[(n-1)/2]` and `pairEnable[(n-1)/2]`. Word 12'hC96 with all compare inputs high gives `pwmOut` = 6'b101001.
- R6: When `pairEnable` for a pair is 0, both outputs of that pair go low at the next clock edge.
- R7: A requested level that goes low is seen on the pin at the first clock edge that samples it.
- R8: A requested level that goes high reaches the pin at the (L+1)-th consecutive clock edge that samples it high, where L is the deadband length.
- R9: L = `dbPeriod` × 2^s. Here s is `dbPrescaleSel` for values 0..5, and s = 5 for values 6 and 7.
- R10: When `dbPeriod` is 0, L is 0 and rising edges reach the pin one clock after they are requested.
- R11: A deadband setting that changes while any output is counting its delay takes effect only once no output is counting.
- R12: A high request that lasts L clocks or fewer never appears on the pin.
- R13: In an enabled pair whose codes are 2'b10 and 2'b01, the two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmpMatch | input | 3 | Compare state, one bit per pair |
| pairEnable | input | 3 | Enable, one bit per pair |
| actionWord | input | 12 | Six two-bit action codes |
| dbPeriod | input | 4 | Deadband period, 0 to 15 |
| dbPrescaleSel | input | 3 | Deadband prescale exponent |
| pwmOut | output | 6 | Shaped outputs, bit 0 is output 1 |

## Verification
A delay counter stuck or left over from an earlier request shows up directly at the pins. The rising edge lands one or more clocks off the L+1 edge, or a pulse that should be swallowed leaks through, and the bench sees it within the first delay window after the request. A decode that reads the wrong code bits or the wrong pair's compare gives a wrong output pattern one clock after the inputs are applied. A length register that reloads while a count is running moves the rising edge of the output that is waiting, within that same dead time.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

  localparam int PERIOD_W    = 4;
  localparam int PRESC_SEL_W = 3;
  localparam int PRESC_STEPS = 6;
  localparam int DB_LEN_W    = PERIOD_W + PRESC_STEPS - 1;

  typedef enum logic [1:0] {
    ACT_FORCE_LOW  = 2'b00,
    ACT_INVERTED   = 2'b01,
    ACT_DIRECT     = 2'b10,
    ACT_FORCE_HIGH = 2'b11
  } actCode_e;

  typedef struct packed {
    logic [DB_LEN_W-1:0] len;
    logic                zeroLen;
  } dbCtl_t;

endpackage

// File: rtl/pwm_pair_control.sv
module pwm_pair_control
  import pwm_pair_pkg::*;
#(
  parameter int NUM_OUTS = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [PERIOD_W-1:0]    dbPeriod,
  input  logic [PRESC_SEL_W-1:0] dbPrescaleSel,
  input  logic [NUM_OUTS-1:0]    dbBusy,
  output dbCtl_t                 dbCtl
);

  localparam int MAX_SHIFT = PRESC_STEPS - 1;

  logic [PRESC_SEL_W-1:0] shiftAmt;
  logic [DB_LEN_W-1:0]    nextLen;
  logic [DB_LEN_W-1:0]    lenReg;
  logic                   loadLen;

  always_comb begin
    if (dbPrescaleSel > PRESC_SEL_W'(MAX_SHIFT)) shiftAmt = PRESC_SEL_W'(MAX_SHIFT);
    else                                         shiftAmt = dbPrescaleSel;
    nextLen = DB_LEN_W'(dbPeriod) << shiftAmt;
    loadLen = ~|dbBusy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lenReg <= '0;
    else if (loadLen) lenReg <= nextLen;
  end

  assign dbCtl.len     = lenReg;
  assign dbCtl.zeroLen = (lenReg == '0);

endmodule

// File: rtl/pwm_pair_datapath.sv
module pwm_pair_datapath
  import pwm_pair_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  localparam int NUM_OUTS = 2 * NUM_PAIRS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PAIRS-1:0]  cmpMatch,
  input  logic [NUM_PAIRS-1:0]  pairEnable,
  input  logic [2*NUM_OUTS-1:0] actionWord,
  input  dbCtl_t                dbCtl,
  output logic [NUM_OUTS-1:0]   dbBusy,
  output logic [NUM_OUTS-1:0]   pwmOut
);

  for (genvar k = 0; k < NUM_OUTS; k++) begin : g_out
    localparam int PAIR = k / 2;

    actCode_e            code;
    logic                want;
    logic [DB_LEN_W-1:0] cnt;
    logic                pin;

    always_comb begin
      code = actCode_e'(actionWord[2*k +: 2]);
      unique case (code)
        ACT_FORCE_LOW:  want = 1'b0;
        ACT_INVERTED:   want = ~cmpMatch[PAIR];
        ACT_DIRECT:     want = cmpMatch[PAIR];
        default:        want = 1'b1;
      endcase
      if (!pairEnable[PAIR]) want = 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pin <= 1'b0;
        cnt <= '0;
      end else if (!want) begin
        pin <= 1'b0;
        cnt <= '0;
      end else if (!pin) begin
        if (dbCtl.zeroLen || cnt >= dbCtl.len) begin
          pin <= 1'b1;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign pwmOut[k] = pin;
    assign dbBusy[k] = (cnt != '0);
  end

endmodule

// File: rtl/pwm_pair_shaper.sv
module pwm_pair_shaper
  import pwm_pair_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  localparam int NUM_OUTS = 2 * NUM_PAIRS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_PAIRS-1:0]   cmpMatch,
  input  logic [NUM_PAIRS-1:0]   pairEnable,
  input  logic [2*NUM_OUTS-1:0]  actionWord,
  input  logic [PERIOD_W-1:0]    dbPeriod,
  input  logic [PRESC_SEL_W-1:0] dbPrescaleSel,
  output logic [NUM_OUTS-1:0]    pwmOut
);

  dbCtl_t              dbCtl;
  logic [NUM_OUTS-1:0] dbBusy;
  logic [DB_LEN_W-1:0] dbLen;

  assign dbLen = dbCtl.len;

  pwm_pair_control #(.NUM_OUTS(NUM_OUTS)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .dbPeriod     (dbPeriod),
    .dbPrescaleSel(dbPrescaleSel),
    .dbBusy       (dbBusy),
    .dbCtl        (dbCtl)
  );

  pwm_pair_datapath #(.NUM_PAIRS(NUM_PAIRS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmpMatch  (cmpMatch),
    .pairEnable(pairEnable),
    .actionWord(actionWord),
    .dbCtl     (dbCtl),
    .dbBusy    (dbBusy),
    .pwmOut    (pwmOut)
  );

endmodule

// File: rtl/pwm_pair_checker.sv
module pwm_pair_checker
  import pwm_pair_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  localparam int NUM_OUTS = 2 * NUM_PAIRS
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_PAIRS-1:0]  pairEnable,
  input logic [2*NUM_OUTS-1:0] actionWord,
  input logic [NUM_OUTS-1:0]   pwmOut,
  input logic [NUM_OUTS-1:0]   dbBusy,
  input logic [DB_LEN_W-1:0]   dbLen
);

  a_r1_reset_low: assert property (@(posedge clk) !rstN |=> pwmOut == '0)
    else $error("R1 outputs not low in reset");

  a_r11_len_locked: assert property (@(posedge clk) disable iff (!rstN)
    (|dbBusy) |=> $stable(dbLen))
    else $error("R11 deadband length changed during a count");

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rstN)
      !pairEnable[p] |=> pwmOut[2*p +: 2] == 2'b00)
      else $error("R6 disabled pair not low");

    a_r13_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
      (pairEnable[p] && actionWord[4*p +: 4] == 4'b0110 &&
       $past(actionWord[4*p +: 4]) == 4'b0110 && $past(pairEnable[p]))
      |-> !(pwmOut[2*p] && pwmOut[2*p+1]))
      else $error("R13 both outputs of a pair high");
  end

  for (genvar k = 0; k < NUM_OUTS; k++) begin : g_outk
    a_r2_forced_low: assert property (@(posedge clk) disable iff (!rstN)
      (actionWord[2*k +: 2] == 2'b00) |=> !pwmOut[k])
      else $error("R2 forced-low output high");

    a_r8_rise_needs_request: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pwmOut[k]) |-> $past(pairEnable[k/2] && actionWord[2*k +: 2] != 2'b00))
      else $error("R8 rise without a request");
  end

endmodule

bind pwm_pair_shaper pwm_pair_checker #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pairEnable(pairEnable),
  .actionWord(actionWord),
  .pwmOut    (pwmOut),
  .dbBusy    (dbBusy),
  .dbLen     (dbLen)
);

// File: tb/pwm_pair_shaper_tb.sv
module pwm_pair_shaper_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] cmpMatch = '0;
  logic [2:0] pairEnable = '0;
  logic [11:0] actionWord = '0;
  logic [3:0] dbPeriod = '0;
  logic [2:0] dbPrescaleSel = '0;
  logic [5:0] pwmOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_pair_shaper u_dut (
    .clk(clk), .rstN(rstN), .cmpMatch(cmpMatch), .pairEnable(pairEnable),
    .actionWord(actionWord), .dbPeriod(dbPeriod), .dbPrescaleSel(dbPrescaleSel),
    .pwmOut(pwmOut)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] exp);
    checks++;
    if (pwmOut !== exp) begin
      fails++;
      $display("FAIL %s: pwmOut=%b expected=%b at %0t", req, pwmOut, exp, $time);
    end
  endtask

  // park everything idle so a new deadband setting is loaded
  task automatic idle_with(input logic [3:0] per, input logic [2:0] sel);
    pairEnable = 3'b000;
    cmpMatch = 3'b000;
    dbPeriod = per;
    dbPrescaleSel = sel;
    tick(2);
  endtask

  task automatic t_reset();
    pairEnable = 3'b111;
    actionWord = 12'hFFF;
    tick(3);
    chk("R1", 6'b000000);
    rstN = 1'b1;
    pairEnable = 3'b000;
    tick(2);
  endtask

  task automatic t_codes();
    idle_with(4'd0, 3'd0);             // R10: period 0 gives no delay
    actionWord = 12'hC96;
    pairEnable = 3'b111;
    cmpMatch = 3'b111;
    tick(1);
    chk("R5 R3 R4 R10", 6'b101001);
    cmpMatch = 3'b000;
    tick(1);
    chk("R4 R7", 6'b100110);
    cmpMatch = 3'b010;
    tick(1);
    chk("R2 R5", 6'b101010);
  endtask

  task automatic t_enable();
    idle_with(4'd0, 3'd0);
    actionWord = 12'hFFF;
    pairEnable = 3'b111;
    tick(1);
    chk("R3", 6'b111111);
    pairEnable = 3'b101;
    tick(1);
    chk("R6", 6'b110011);
  endtask

  task automatic t_delay();
    idle_with(4'd3, 3'd1);             // L = 6
    actionWord = 12'h006;              // out1 direct, out2 inverted
    pairEnable = 3'b001;               // cmp 0: out2 requested
    tick(6);
    chk("R8 before", 6'b000000);
    tick(1);
    chk("R8 edge", 6'b000010);
    cmpMatch = 3'b001;
    tick(1);
    chk("R7 R13", 6'b000000);
    tick(5);
    chk("R8 R13 before", 6'b000000);
    tick(1);
    chk("R8 second", 6'b000001);
  endtask

  task automatic t_prescale();
    idle_with(4'd1, 3'd7);             // clamps to 32
    actionWord = 12'h003;
    pairEnable = 3'b001;
    tick(32);
    chk("R9 before", 6'b000000);
    tick(1);
    chk("R9 edge", 6'b000001);
  endtask

  task automatic t_short();
    idle_with(4'd3, 3'd1);             // L = 6
    actionWord = 12'h003;
    pairEnable = 3'b001;
    tick(6);
    pairEnable = 3'b000;
    tick(1);
    chk("R12", 6'b000000);
    tick(4);
    chk("R12 later", 6'b000000);
  endtask

  task automatic t_lock();
    idle_with(4'd3, 3'd1);             // L = 6
    actionWord = 12'h003;
    pairEnable = 3'b001;
    tick(2);
    dbPeriod = 4'd1;                   // request L = 1 mid-count
    dbPrescaleSel = 3'd0;
    tick(4);
    chk("R11 held", 6'b000000);
    tick(1);
    chk("R11 old length", 6'b000001);
    pairEnable = 3'b000;
    tick(2);
    pairEnable = 3'b001;
    tick(1);
    chk("R11 new length before", 6'b000000);
    tick(1);
    chk("R11 new length", 6'b000001);
  endtask

  initial begin
    t_reset();
    t_codes();
    t_enable();
    t_delay();
    t_prescale();
    t_short();
    t_lock();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule